// File: doc/BRIEF.md
# Integer Execution Unit with Packed Divide

This block is the integer arithmetic unit of a 32-bit core. It takes an operation code and two source operands, then returns a result word with a one-cycle valid strobe and two flags: overflow and zero. It supports add, subtract, signed and unsigned multiply, signed and unsigned divide, three bitwise operations and three shifts.

All operations except divide finish one cycle after they are accepted. Divide uses a restoring iterative engine. While it runs, it raises `busy` for 32 cycles, and the unit accepts no new operation until `busy` falls. Divide returns a packed word: the quotient is in the upper half and the remainder is in the lower half. The overflow flag reports when either part does not fit in its half, or when the divisor is zero.

Operands go in on `src_a` (first source) and `src_b` (second source). An operation is accepted in a cycle where `in_valid` is high and `busy` is low.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 returns `src_a + src_b` and opcode 1 returns `src_a - src_b`, both modulo 2^32. Overflow is set when the true signed result lies outside [-2^31, 2^31-1].
- R2: Opcode 2 returns the low 32 bits of the signed product. Overflow is set when the full signed product lies outside [-2^31, 2^31-1].
- R3: Opcode 3 returns the low 32 bits of the unsigned product. Overflow is set when the full unsigned product is 2^32 or larger.
- R4: Opcode 4 is a signed divide of `src_a` by `src_b`. The quotient truncates toward zero and goes in bits 31:16. The remainder has the sign of the dividend and goes in bits 15:0.
- R5: Opcode 5 is an unsigned divide of `src_a` by `src_b`. The quotient goes in bits 31:16 and the remainder in bits 15:0.
- R6: A divide with a zero divisor returns result 0 with overflow set. For any other divide, overflow is set when the quotient or the remainder falls outside the 16-bit range: signed for opcode 4, unsigned for opcode 5.
- R7: Opcodes 6, 7 and 8 return `src_a` XOR, OR and AND `src_b`, with overflow clear.
- R8: Opcodes 9, 10 and 11 shift `src_a` by `src_b[4:0]`. Opcode 9 shifts left, opcode 10 shifts right with zero fill, and opcode 11 shifts right filling with bit 31. Overflow is clear.
- R9: Every opcode other than 4 and 5 gives `out_valid` high for exactly one cycle, in the cycle after acceptance.
- R10: A divide raises `busy` from the cycle after acceptance for exactly 32 cycles. The result appears with `out_valid` in the first cycle where `busy` is low again.
- R11: While `busy` is high, `in_valid` is ignored: no result is ever produced for that operation.
- R12: The `zero` flag is high with each result exactly when that result word is 0.
- R13: During reset, `out_valid`, `busy`, `result`, `ovf` and `zero` are all 0.
- R14: Opcodes 12 to 15 complete in one cycle with result 0 and overflow clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation request |
| op | input | 4 | Operation code |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| busy | output | 1 | Divide in progress; requests are ignored |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Result word |
| ovf | output | 1 | Overflow flag for the result |
| zero | output | 1 | Result-is-zero flag |

## Verification
The bench builds the unit at its default width of 32, so each result half is 16 bits and the shift amount is 5 bits. That width brings the signed extremes within reach: -2^31 divided by -1, products just past 2^31, shifts by 31 and by amounts whose upper bits must be dropped. Quotients and remainders sit right on the ±2^15 and 2^16 limits of the packed halves. At this width the 32-cycle divide latency is short enough to count cycle by cycle, and the bench also injects a request while the divider is busy.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_MULU = 4'd3,
    OP_DIV  = 4'd4,
    OP_DIVU = 4'd5,
    OP_XOR  = 4'd6,
    OP_OR   = 4'd7,
    OP_AND  = 4'd8,
    OP_LSL  = 4'd9,
    OP_LSR  = 4'd10,
    OP_ASR  = 4'd11
  } iexu_op_e;

  function automatic logic op_is_div(input logic [3:0] code);
    return (code == OP_DIV) || (code == OP_DIVU);
  endfunction
endpackage

// File: rtl/iexu_arith.sv
module iexu_arith
  import iexu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int PW = 2 * W;

  logic [W:0]    sum_x;
  logic [W:0]    dif_x;
  logic [PW-1:0] prod_s;
  logic [PW-1:0] prod_u;
  logic          sum_ovf;
  logic          dif_ovf;
  logic          muls_ovf;
  logic          mulu_ovf;

  always_comb begin
    sum_x  = {a[W-1], a} + {b[W-1], b};
    dif_x  = {a[W-1], a} - {b[W-1], b};
    prod_s = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    // a signed result fits when the extra top bit agrees with the sign bit
    sum_ovf  = sum_x[W] ^ sum_x[W-1];
    dif_ovf  = dif_x[W] ^ dif_x[W-1];
    muls_ovf = (prod_s[PW-1:W-1] != {(W+1){1'b0}}) &&
               (prod_s[PW-1:W-1] != {(W+1){1'b1}});
    mulu_ovf = (prod_u[PW-1:W] != {W{1'b0}});
  end

  always_comb begin
    res = '0;
    ovf = 1'b0;
    unique case (op)
      OP_ADD:  begin res = sum_x[W-1:0];  ovf = sum_ovf;  end
      OP_SUB:  begin res = dif_x[W-1:0];  ovf = dif_ovf;  end
      OP_MUL:  begin res = prod_s[W-1:0]; ovf = muls_ovf; end
      OP_MULU: begin res = prod_u[W-1:0]; ovf = mulu_ovf; end
      default: begin res = '0;            ovf = 1'b0;     end
    endcase
  end
endmodule

// File: rtl/iexu_bitops.sv
module iexu_bitops
  import iexu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] amt;

  always_comb begin
    amt = b[SHW-1:0];
    unique case (op)
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_LSL:  res = a << amt;
      OP_LSR:  res = a >> amt;
      OP_ASR:  res = $unsigned($signed(a) >>> amt);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/iexu_divider.sv
module iexu_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] packed_res,
  output logic         ovf
);
  localparam int H   = W / 2;
  localparam int CW  = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvsr_q, dvsr_d;
  logic          qneg_q, qneg_d;
  logic          rneg_q, rneg_d;
  logic          sgn_q, sgn_d;
  logic          dz_q, dz_d;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          fits;
  logic [W-1:0]  rem_step;
  logic [W-1:0]  quo_step;
  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic [W-1:0]  q_fin;
  logic [W-1:0]  r_fin;
  logic          q_bad;
  logic          r_bad;

  // one restoring step: shift in the next dividend bit, try to subtract
  always_comb begin
    shifted  = {rem_q, quo_q[W-1]};
    trial    = shifted - {1'b0, dvsr_q};
    fits     = ~trial[W];
    rem_step = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_step = {quo_q[W-2:0], fits};
  end

  always_comb begin
    mag_a = (is_signed && dividend[W-1]) ? (~dividend + 1'b1) : dividend;
    mag_b = (is_signed && divisor[W-1])  ? (~divisor + 1'b1)  : divisor;
  end

  // sign fix-up and range check on the final step
  always_comb begin
    q_fin = qneg_q ? (~quo_step + 1'b1) : quo_step;
    r_fin = rneg_q ? (~rem_step + 1'b1) : rem_step;
    if (sgn_q) begin
      q_bad = (q_fin[W-1:H-1] != {(H+1){1'b0}}) && (q_fin[W-1:H-1] != {(H+1){1'b1}});
      r_bad = (r_fin[W-1:H-1] != {(H+1){1'b0}}) && (r_fin[W-1:H-1] != {(H+1){1'b1}});
    end else begin
      q_bad = (q_fin[W-1:H] != {H{1'b0}});
      r_bad = (r_fin[W-1:H] != {H{1'b0}});
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvsr_d = dvsr_q;
    qneg_d = qneg_q;
    rneg_d = rneg_q;
    sgn_d  = sgn_q;
    dz_d   = dz_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      rem_d  = '0;
      quo_d  = mag_a;
      dvsr_d = mag_b;
      sgn_d  = is_signed;
      qneg_d = is_signed && (dividend[W-1] ^ divisor[W-1]);
      rneg_d = is_signed && dividend[W-1];
      dz_d   = (divisor == '0);
    end else if (busy_q) begin
      rem_d = rem_step;
      quo_d = quo_step;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvsr_q <= '0;
      qneg_q <= 1'b0;
      rneg_q <= 1'b0;
      sgn_q  <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvsr_q <= dvsr_d;
      qneg_q <= qneg_d;
      rneg_q <= rneg_d;
      sgn_q  <= sgn_d;
      dz_q   <= dz_d;
    end
  end

  always_comb begin
    busy       = busy_q;
    done       = busy_q && (cnt_q == LAST);
    packed_res = dz_q ? '0 : {q_fin[H-1:0], r_fin[H-1:0]};
    ovf        = dz_q | q_bad | r_bad;
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         zero
);
  logic [1:0]   rst_sync_q;
  logic         rst_int_n;

  logic         div_busy;
  logic         div_done;
  logic [W-1:0] div_res;
  logic         div_ovf;
  logic [W-1:0] ar_res;
  logic         ar_ovf;
  logic [W-1:0] bit_res;

  logic         accept;
  logic         fast_go;
  logic         div_go;
  logic         is_arith;
  logic         is_bit;

  logic         vld_d, vld_q;
  logic         res_en;
  logic [W-1:0] res_d, res_q;
  logic         ovf_d, ovf_q;
  logic         zero_d, zero_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  iexu_arith #(.W(W)) u_arith (
    .op (op),
    .a  (src_a),
    .b  (src_b),
    .res(ar_res),
    .ovf(ar_ovf)
  );

  iexu_bitops #(.W(W)) u_bitops (
    .op (op),
    .a  (src_a),
    .b  (src_b),
    .res(bit_res)
  );

  iexu_divider #(.W(W)) u_div (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (div_go),
    .is_signed (op == OP_DIV),
    .dividend  (src_a),
    .divisor   (src_b),
    .busy      (div_busy),
    .done      (div_done),
    .packed_res(div_res),
    .ovf       (div_ovf)
  );

  always_comb begin
    accept   = in_valid && !div_busy;
    fast_go  = accept && !op_is_div(op);
    div_go   = accept && op_is_div(op);
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_MULU);
    is_bit   = (op >= OP_XOR) && (op <= OP_ASR);
  end

  // next-state selection of the output stage
  always_comb begin
    vld_d  = fast_go || div_done;
    res_en = vld_d;
    res_d  = '0;
    ovf_d  = 1'b0;
    if (div_done) begin
      res_d = div_res;
      ovf_d = div_ovf;
    end else if (is_arith) begin
      res_d = ar_res;
      ovf_d = ar_ovf;
    end else if (is_bit) begin
      res_d = bit_res;
    end
    zero_d = (res_d == '0);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q  <= '0;
      ovf_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (res_en) begin
      res_q  <= res_d;
      ovf_q  <= ovf_d;
      zero_q <= zero_d;
    end
  end

  assign busy      = div_busy;
  assign out_valid = vld_q;
  assign result    = res_q;
  assign ovf       = ovf_q;
  assign zero      = zero_q;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic [W-1:0] src_a,
  input logic [W-1:0] src_b,
  input logic         busy,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         ovf
);
  localparam int CW = $clog2(W) + 2;

  logic [CW-1:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  p_fast_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && op != 4'd4 && op != 4'd5) |=> out_valid);

  p_div_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && (op == 4'd4 || op == 4'd5)) |=> (busy && !out_valid));

  p_busy_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len_q <= CW'(W));

  p_div_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (out_valid && busy_len_q == CW'(W)));

  p_no_result_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);

  p_xor_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && op == 4'd6) |=> (result == ($past(src_a) ^ $past(src_b)) && !ovf));

  p_undef_op_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && op >= 4'd12) |=> (result == '0 && !ovf));
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .src_a    (src_a),
  .src_b    (src_b),
  .busy     (busy),
  .out_valid(out_valid),
  .result   (result),
  .ovf      (ovf)
);

// File: tb/test_int_exec_unit.sv
`timescale 1ns/1ps
module test_int_exec_unit;
  localparam int W = 32;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        zf;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic        busy;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf;
  logic        zero;

  int   n_checks = 0;
  int   n_errors = 0;
  int   n_pushed = 0;
  int   n_seen   = 0;
  exp_t sb_q[$];

  int_exec_unit #(.W(W)) i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .busy(busy), .out_valid(out_valid),
    .result(result), .ovf(ovf), .zero(zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  function automatic void model(input logic [3:0] o, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] r,
                                output logic v);
    longint sa, sb, ua, ub, t, q, m;
    logic [63:0] pu;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'd0, a});
    ub = longint'({32'd0, b});
    r = 32'd0;
    v = 1'b0;
    case (o)
      4'd0, 4'd1, 4'd2: begin
        t = (o == 4'd0) ? sa + sb : (o == 4'd1) ? sa - sb : sa * sb;
        r = t[31:0];
        v = (t > 64'sd2147483647) || (t < -64'sd2147483648);
      end
      4'd3: begin pu = {32'd0, a} * {32'd0, b}; r = pu[31:0]; v = (pu[63:32] != 0); end
      4'd4: begin
        if (b == 0) begin r = 0; v = 1; end
        else begin
          q = sa / sb; m = sa % sb;
          r = {q[15:0], m[15:0]};
          v = (q > 32767) || (q < -32768) || (m > 32767) || (m < -32768);
        end
      end
      4'd5: begin
        if (b == 0) begin r = 0; v = 1; end
        else begin
          q = ua / ub; m = ua % ub;
          r = {q[15:0], m[15:0]};
          v = (q > 65535) || (m > 65535);
        end
      end
      4'd6:  r = a ^ b;
      4'd7:  r = a | b;
      4'd8:  r = a & b;
      4'd9:  r = a << b[4:0];
      4'd10: r = a >> b[4:0];
      4'd11: r = $unsigned($signed(a) >>> b[4:0]);
      default: begin r = 0; v = 0; end
    endcase
  endfunction

  // driver: pushes the expected item, applies the request, checks timing
  task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input string tag, input bit inject = 1'b0);
    exp_t e;
    int   cyc;
    model(o, a, b, e.res, e.ovf);
    e.zf  = (e.res == 32'd0);
    e.tag = tag;
    sb_q.push_back(e);
    n_pushed++;
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (o == 4'd4 || o == 4'd5) begin
      cyc = 0;
      while (busy) begin
        cyc++;
        if (inject && cyc == 5) begin
          in_valid = 1'b1; op = 4'd0; src_a = 32'd7; src_b = 32'd9;
        end else begin
          in_valid = 1'b0;
        end
        @(negedge clk);
        if (cyc > 100) break;
      end
      in_valid = 1'b0;
      check(cyc == 32, {tag, " R10 busy length"}, 32'(cyc), 32'd32);
      check(out_valid == 1'b1, {tag, " R10 valid when busy falls"}, {31'd0, out_valid}, 32'd1);
    end else begin
      check(out_valid == 1'b1, {tag, " R9 one-cycle latency"}, {31'd0, out_valid}, 32'd1);
    end
  endtask

  // monitor: pops and compares every produced result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_seen++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R11 unexpected result", result, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result == e.res, {e.tag, " result"}, result, e.res);
        check(ovf == e.ovf, {e.tag, " ovf"}, {31'd0, ovf}, {31'd0, e.ovf});
        check(zero == e.zf, {e.tag, " R12 zero flag"}, {31'd0, zero}, {31'd0, e.zf});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 4'd0; src_a = 0; src_b = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R13 reset out_valid", {31'd0, out_valid}, 0);
    check(busy == 0, "R13 reset busy", {31'd0, busy}, 0);
    check(result == 0, "R13 reset result", result, 0);
    check(ovf == 0 && zero == 0, "R13 reset flags", {30'd0, ovf, zero}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(4'd0, 32'd100, 32'd23, "R1 add");
    issue(4'd0, 32'h7fffffff, 32'd1, "R1 add overflow");
    issue(4'd0, 32'hffffffff, 32'd1, "R1 add wrap to zero");
    issue(4'd1, 32'h80000000, 32'd1, "R1 sub underflow");
    issue(4'd1, 32'd5, 32'd9, "R1 sub negative");
    issue(4'd2, 32'hfffffffd, 32'd7, "R2 mul signed");
    issue(4'd2, 32'h00010000, 32'h00008000, "R2 mul overflow");
    issue(4'd2, 32'hffff0000, 32'h00008000, "R2 mul min fits");
    issue(4'd3, 32'h00010000, 32'h00010000, "R3 mulu overflow");
    issue(4'd3, 32'hffffffff, 32'd1, "R3 mulu fits");
    issue(4'd4, 32'hffffff9c, 32'd7, "R4 div neg dividend");
    issue(4'd4, 32'd100, 32'hfffffff9, "R4 div neg divisor");
    issue(4'd4, 32'hffff8000, 32'd1, "R4 div quotient at min");
    issue(4'd4, 32'h80000000, 32'hffffffff, "R6 div signed overflow");
    issue(4'd5, 32'd1000003, 32'd1000, "R5 divu");
    issue(4'd5, 32'h0000ffff, 32'd1, "R5 divu quotient at max");
    issue(4'd5, 32'h00010000, 32'd1, "R6 divu quotient too wide");
    issue(4'd5, 32'h00123456, 32'h00100000, "R6 divu remainder too wide");
    issue(4'd4, 32'd55, 32'd0, "R6 div by zero");
    issue(4'd5, 32'd0, 32'd0, "R6 divu by zero");
    issue(4'd6, 32'hf0f0a5a5, 32'h0ff05a5a, "R7 xor");
    issue(4'd7, 32'h12340000, 32'h00005678, "R7 or");
    issue(4'd8, 32'hf0f0f0f0, 32'h0f0f0f0f, "R7 and to zero");
    issue(4'd9, 32'h00000001, 32'd31, "R8 lsl 31");
    issue(4'd9, 32'h00000003, 32'h00000024, "R8 lsl upper bits ignored");
    issue(4'd10, 32'h80000000, 32'd31, "R8 lsr");
    issue(4'd11, 32'h80000000, 32'd4, "R8 asr sign fill");
    issue(4'd11, 32'h40000000, 32'd30, "R8 asr positive");
    issue(4'd13, 32'hdeadbeef, 32'h1, "R14 undefined opcode");
    issue(4'd4, 32'hfffffc00, 32'd3, "R11 div with ignored request", 1'b1);
    issue(4'd0, 32'd1, 32'd2, "R9 back-to-back after divide");

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R11 scoreboard drained", 32'(sb_q.size()), 0);
    check(n_seen == n_pushed, "R11 result count", 32'(n_seen), 32'(n_pushed));
    finish_up();
  end
endmodule